// File: doc/BRIEF.md
# Speculative Narrow-Shift Single-Precision Adder

This block adds or subtracts two single-precision IEEE-754 operands through a datapath whose alignment and normalisation shifters cover only 2^SHIFT_LOG bit positions. Programs often keep their operand exponents close together. For such operations the small shifters are enough, and the block returns the exact correctly rounded sum.

Some operations need a wider shift, or involve an operand or result the narrow datapath does not represent. For these the block does not guess. It raises a fallback flag alongside the output, and the system above it re-runs that operation on a full-precision unit or in software.

A build parameter chooses whether the block orders the operands by magnitude. Without that ordering, any pair where the second operand is larger is sent to fallback. The pipeline has a fixed latency of two clock cycles. A new operation may enter on every cycle.

Top module: `spec_fadd`

## Requirements
- R1: A valid operation accepted on a rising edge produces `out_valid` high exactly two rising edges later. `out_valid` is low after reset and in every cycle that follows an idle input cycle in the same way.
- R2: When `fallback` is low with `out_valid` high, `result` is bit-identical to an IEEE-754 single-precision addition with round-to-nearest-even. The bit layout is sign in bit 31, biased exponent in bits 30:23, and fraction in bits 22:0.
- R3: An operand whose exponent field is 0 (zero or denormal) or 255 (infinity or NaN) forces `fallback`.
- R4: Let L = 2^SHIFT_LOG. An exponent difference greater than L forces `fallback`. A difference of exactly L is computed in hardware.
- R5: A result whose leading one lies more than L positions below the hidden-bit position of the larger operand forces `fallback`. A cancellation of exactly L positions is computed.
- R6: A rounded result exponent of 255 or more (overflow) forces `fallback`. So does a result exponent of 0 or less before rounding, which covers underflow and an exact zero result.
- R7: With `sub` high, the block computes op_a minus op_b by inverting the sign of op_b before the effective operation is chosen.
- R8: With HAS_SWAP=1, operands are ordered by magnitude, so a larger op_b is computed normally. With HAS_SWAP=0, an op_b whose magnitude bits (30:0) exceed those of op_a forces `fallback`.
- R9: `fallback` is high only together with `out_valid`. While `fallback` is high or `out_valid` is low, `result` is zero.
- R10: Ties round to even. An exactly halfway remainder leaves an even mantissa unchanged and rounds an odd mantissa up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sub | input | 1 | 1 selects op_a minus op_b |
| out_valid | output | 1 | Result slot valid |
| result | output | 32 | Rounded sum, zero when not valid or on fallback |
| fallback | output | 1 | Operation must be re-executed elsewhere |

## Verification
Random operand pairs are generated with exponent gaps that straddle the shift limit. This separates computed operations from those sent to fallback right at the boundary.

Pairs with equal exponents and near-equal mantissas drive deep cancellation, which exercises the normalisation limit. Directed pairs cover further cases: halfway ties with even and odd mantissas, carry-out sums, an exact gap of L versus L+1, overflow, underflow, and specials. Two instances run side by side, one with operand ordering and one without. A larger second operand is therefore seen computed in one instance and flagged in the other.

// File: rtl/spec_fadd.sv
module spec_fadd #(
  parameter int SHIFT_LOG = 3,
  parameter bit HAS_SWAP  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        sub,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        fallback
);
  localparam int LIM = 1 << SHIFT_LOG;
  localparam int W   = 24 + LIM;
  localparam int DW  = SHIFT_LOG + 1;

  logic        sb_eff, b_big, swp, hi_s, lo_s, special, far, fb0;
  logic [31:0] hi, lo;
  logic [7:0]  diff;
  logic [DW-1:0] dsh;
  logic [W-1:0]  a_ext, b_ext;
  logic [W:0]    sum0;

  assign sb_eff  = op_b[31] ^ sub;
  assign b_big   = op_b[30:0] > op_a[30:0];
  assign swp     = HAS_SWAP && b_big;
  assign hi      = swp ? op_b : op_a;
  assign lo      = swp ? op_a : op_b;
  assign hi_s    = swp ? sb_eff : op_a[31];
  assign lo_s    = swp ? op_a[31] : sb_eff;
  assign special = (op_a[30:23] == 8'd0) || (op_a[30:23] == 8'hFF) ||
                   (op_b[30:23] == 8'd0) || (op_b[30:23] == 8'hFF);
  assign diff    = hi[30:23] - lo[30:23];
  assign far     = 32'(diff) > LIM;
  assign fb0     = special || far || (!HAS_SWAP && b_big);
  assign dsh     = diff[DW-1:0];
  assign a_ext   = {1'b1, hi[22:0], {LIM{1'b0}}};
  assign b_ext   = {1'b1, lo[22:0], {LIM{1'b0}}} >> dsh;
  assign sum0    = (hi_s ^ lo_s) ? ({1'b0, a_ext} - {1'b0, b_ext})
                                 : ({1'b0, a_ext} + {1'b0, b_ext});

  logic         v1, f1, s1;
  logic [7:0]   e1;
  logic [W:0]   m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; f1 <= 1'b0; s1 <= 1'b0; e1 <= '0; m1 <= '0;
    end else begin
      v1 <= in_valid;
      f1 <= fb0;
      s1 <= hi_s;
      e1 <= hi[30:23];
      m1 <= sum0;
    end
  end

  logic          hit, grd, stk, rup, fb2;
  logic [DW-1:0] sh;
  logic [W:0]    norm;
  logic [23:0]   mant;
  logic [24:0]   mr;
  logic [22:0]   frac;
  int            e_pre, e_fin;

  always_comb begin
    hit = 1'b0;
    sh  = '0;
    for (int k = 0; k <= LIM + 1; k++) begin
      if (!hit && m1[W-k]) begin
        hit = 1'b1;
        sh  = DW'(k);
      end
    end
  end

  assign norm  = m1 << sh;
  assign mant  = norm[W:W-23];
  assign grd   = norm[W-24];
  assign stk   = |norm[W-25:0];
  assign rup   = grd & (stk | mant[0]);
  assign mr    = {1'b0, mant} + {24'd0, rup};
  assign frac  = mr[24] ? mr[23:1] : mr[22:0];
  assign e_pre = int'(e1) + 1 - int'(sh);
  assign e_fin = e_pre + int'(mr[24]);
  assign fb2   = f1 || !hit || (e_pre <= 0) || (e_fin >= 255);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; fallback <= 1'b0; result <= '0;
    end else begin
      out_valid <= v1;
      fallback  <= v1 && fb2;
      result    <= (v1 && !fb2) ? {s1, e_fin[7:0], frac} : 32'd0;
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R3
  special_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ((op_a[30:23] == 8'd0) || (op_a[30:23] == 8'hFF) ||
                 (op_b[30:23] == 8'd0) || (op_b[30:23] == 8'hFF)) |-> ##2 fallback);

  // R4
  far_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ((op_a[30:23] > op_b[30:23]) ? 32'(op_a[30:23] - op_b[30:23])
                                             : 32'(op_b[30:23] - op_a[30:23])) > LIM
    |-> ##2 fallback);

  // R6
  exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !fallback |-> (result[30:23] != 8'd0) && (result[30:23] != 8'hFF));

  // R9
  fb_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fallback || !out_valid) |-> (result == 32'd0) && (!fallback || out_valid));

  generate
    if (!HAS_SWAP) begin : g_noswap
      // R8
      noswap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_b[30:0] > op_a[30:0]) |-> ##2 fallback);
    end
  endgenerate
endmodule

// File: tb/tb_spec_fadd.sv
module tb_spec_fadd;
  localparam int SL  = 3;
  localparam int LIM = 1 << SL;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, sub = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic v_s, f_s, v_n, f_n;
  logic [31:0] y_s, y_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spec_fadd #(.SHIFT_LOG(SL), .HAS_SWAP(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub(sub), .out_valid(v_s), .result(y_s), .fallback(f_s));
  spec_fadd #(.SHIFT_LOG(SL), .HAS_SWAP(1'b0)) dut_ns (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub(sub), .out_valid(v_n), .result(y_n), .fallback(f_n));

  typedef struct { logic v; logic [31:0] y; logic f; string tag; } exp_t;
  exp_t qs[$], qn[$];

  function automatic void ref_add(input logic [31:0] a, b, input logic s, input bit swap,
                                  output logic [31:0] y, output logic f);
    int ea, eb, emin, ebig, p, er;
    logic sa, sb, sg;
    logic [127:0] A, B, mag, rem, half;
    logic [24:0] keep;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    sa = a[31]; sb = b[31] ^ s;
    y = '0; f = 1'b0;
    if (ea == 0 || ea == 255 || eb == 0 || eb == 255) f = 1'b1;
    if (!swap && b[30:0] > a[30:0]) f = 1'b1;
    if ((ea > eb ? ea - eb : eb - ea) > LIM) f = 1'b1;
    if (f) return;
    emin = ea < eb ? ea : eb;
    ebig = ea < eb ? eb : ea;
    A = {104'd0, 1'b1, a[22:0]} << (ea - emin);
    B = {104'd0, 1'b1, b[22:0]} << (eb - emin);
    if (sa == sb) begin mag = A + B; sg = sa; end
    else if (A >= B) begin mag = A - B; sg = sa; end
    else begin mag = B - A; sg = sb; end
    if (mag == 0) begin f = 1'b1; return; end
    p = 0;
    for (int i = 0; i < 128; i++) if (mag[i]) p = i;
    er = emin + p - 23;
    if (ebig - er > LIM || er <= 0) begin f = 1'b1; return; end
    if (p > 23) begin
      keep = 25'(mag >> (p - 23));
      rem  = mag & ((128'd1 << (p - 23)) - 1);
      half = 128'd1 << (p - 24);
      if (rem > half || (rem == half && keep[0])) keep = keep + 1;
    end else keep = 25'(mag << (23 - p));
    if (keep[24]) begin keep = keep >> 1; er = er + 1; end
    if (er >= 255) begin f = 1'b1; return; end
    y = {sg, er[7:0], keep[22:0]};
  endfunction

  task automatic cmp(input exp_t e, input logic v, input logic [31:0] y, input logic f,
                     input string who);
    total++;
    if (v !== e.v || y !== e.y || f !== e.f) begin
      bad++;
      $display("FAIL %s %s: got v=%0b y=%h f=%0b exp v=%0b y=%h f=%0b",
               e.tag, who, v, y, f, e.v, e.y, e.f);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, b, input logic s, input string tag);
    exp_t es, en;
    @(negedge clk);
    if (qs.size() >= 2) begin
      cmp(qs.pop_front(), v_s, y_s, f_s, "swap");
      cmp(qn.pop_front(), v_n, y_n, f_n, "noswap");
    end
    in_valid = v; op_a = a; op_b = b; sub = s;
    es.v = v; es.tag = tag; en.v = v; en.tag = tag;
    es.y = '0; es.f = 1'b0; en.y = '0; en.f = 1'b0;
    if (v) begin
      ref_add(a, b, s, 1'b1, es.y, es.f);
      ref_add(a, b, s, 1'b0, en.y, en.f);
    end
    qs.push_back(es); qn.push_back(en);
  endtask

  function automatic logic [31:0] mk(input logic sg, input int e, input logic [22:0] m);
    return {sg, 8'(e), m};
  endfunction

  initial begin
    exp_t idle;
    idle.v = 1'b0; idle.y = '0; idle.f = 1'b0; idle.tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    qs.push_back(idle); qs.push_back(idle);
    qn.push_back(idle); qn.push_back(idle);
    step(1'b0, 32'd0, 32'd0, 1'b0, "R1");
    // R2 plain sums, R7 subtraction
    step(1'b1, 32'h3F800000, 32'h3F800000, 1'b0, "R2");
    step(1'b1, 32'h40400000, 32'h3F800000, 1'b1, "R7");
    step(1'b1, 32'h40400000, 32'h3F800000, 1'b0, "R2");
    step(1'b0, 32'h40400000, 32'h3F800000, 1'b0, "R1");
    // R8 larger second operand
    step(1'b1, 32'h3F800000, 32'h40400000, 1'b0, "R8");
    step(1'b1, 32'h3F800000, 32'h40400000, 1'b1, "R8");
    // R10 ties
    step(1'b1, 32'h3F800001, 32'h3F800000, 1'b0, "R10");
    step(1'b1, 32'h3F800003, 32'h3F800000, 1'b0, "R10");
    // R4 gap of exactly LIM and LIM+1
    step(1'b1, mk(0, 127, 23'h12345), mk(0, 127 - LIM, 23'h7FFFFF), 1'b0, "R4");
    step(1'b1, mk(0, 127, 23'h12345), mk(0, 126 - LIM, 23'h7FFFFF), 1'b0, "R4");
    // R5 cancellation of LIM and LIM+1
    step(1'b1, mk(0, 127, 23'd1 << (23 - LIM)), 32'h3F800000, 1'b1, "R5");
    step(1'b1, mk(0, 127, 23'd1 << (22 - LIM)), 32'h3F800000, 1'b1, "R5");
    // R3 specials
    step(1'b1, 32'h7F800000, 32'h3F800000, 1'b0, "R3");
    step(1'b1, 32'h3F800000, 32'h7FC00000, 1'b0, "R3");
    step(1'b1, 32'h00000000, 32'h3F800000, 1'b0, "R3");
    step(1'b1, 32'h3F800000, 32'h00000001, 1'b0, "R3");
    // R6 overflow, underflow, exact zero
    step(1'b1, 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R6");
    step(1'b1, 32'h00C00000, 32'h00800000, 1'b1, "R6");
    step(1'b1, 32'h3F800000, 32'h3F800000, 1'b1, "R6");
    // R9 back-to-back mixed
    step(1'b1, 32'h7F800000, 32'h3F800000, 1'b0, "R9");
    step(1'b1, 32'h3F800000, 32'h3F800000, 1'b0, "R9");
    // R2 random
    for (int n = 0; n < 3000; n++) begin
      int ea, eb;
      logic [22:0] ma, mb;
      ea = 64 + int'($urandom % 128);
      ma = 23'($urandom);
      if ($urandom % 4 == 0) begin
        eb = ea;
        mb = ma ^ 23'($urandom % 64);
      end else begin
        eb = ea + int'($urandom % (2 * LIM + 5)) - (LIM + 2);
        mb = 23'($urandom);
      end
      step(($urandom % 5) != 0, mk(1'($urandom), ea, ma), mk(1'($urandom), eb, mb),
           1'($urandom), "R2");
    end
    step(1'b0, 32'd0, 32'd0, 1'b0, "R1");
    step(1'b0, 32'd0, 32'd0, 1'b0, "R1");
    step(1'b0, 32'd0, 32'd0, 1'b0, "R1");
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule